// File: doc/BRIEF.md
# Three-Bit Framed Odd-Parity Detector

This block watches a serial bit stream and cuts it into back-to-back frames of three accepted bits, with no overlap between frames. A bit counts only in a cycle where the qualifier `bit_vld` is high. On the third accepted bit of a frame, the block raises `z_out` in that same cycle when the frame holds an odd number of ones. The odd-parity frames are 001, 010, 100 and 111. The block then starts a fresh frame.

The machine has five states, which is the minimum. After two bits it does not keep the two bits themselves, only their parity: the prefixes "00" and "11" share one state, and "01" and "10" share another. The state codes are assigned by adjacency. Idle is 000. After a first bit of 0 the code is 100, and after a first bit of 1 it is 101. The even-prefix state is 110 and the odd-prefix state is 111. With these codes, the detection term depends only on the low code bit and the incoming bit. Codes 001, 010 and 011 are unused, and any of them falls back to idle on the next accepted bit.

Top module: `triad_parity_detector`

## Requirements
- R1: After a synchronous reset, the first accepted bit starts a new frame, and `z_out` is 0 in every cycle that is not the third accepted bit of a frame.
- R2: In the cycle of the third accepted bit of a frame, `z_out` is 1 exactly when the three bits, in order of arrival, form 001, 010, 100 or 111 (an odd count of ones). For 000, 011, 101 and 110 it is 0. The output is combinational and shows in the same cycle as that bit.
- R3: `z_out` is 0 while the first or the second accepted bit of a frame is on the input.
- R4: Frames do not overlap. The accepted bit that follows the third bit of a frame is the first bit of the next frame.
- R5: In a cycle with `bit_vld` low, `z_out` is 0 and `bit_in` is ignored. Frame progress is kept, so idle cycles anywhere inside a frame do not change which bit comes next or the value detected.
- R6: A reset asserted partway through a frame throws away the partial frame. Detection restarts with the next accepted bit after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept |
| bit_in | input | 1 | Serial data bit |
| z_out | output | 1 | Mealy detect flag, valid on the third accepted bit |

## Verification
The bench drives all eight frame values, so it catches a design that tests for the wrong set of patterns or that tracks the first bit instead of the prefix parity. It sends frames back to back to expose a sliding-window detector, which would fire on bits that belong to two frames. It puts idle cycles between the bits of a frame, to catch a design that advances or flags on unqualified cycles. It also resets partway through a frame, which shows up a design that keeps stale prefix state.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    // Adjacency-driven codes: bit2 = inside a frame, bit1 = two bits seen,
    // bit0 = first bit (one seen) or prefix parity (two seen).
    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_HEAD0  = 3'b100,
        ST_HEAD1  = 3'b101,
        ST_PAR_EV = 3'b110,
        ST_PAR_OD = 3'b111
    } tpd_state_e;

    localparam int unsigned TPD_STATE_W = $bits(tpd_state_e);

    function automatic tpd_state_e tpd_advance(input tpd_state_e cur, input logic b);
        tpd_state_e nxt;
        case (cur)
            ST_IDLE:             nxt = b ? ST_HEAD1 : ST_HEAD0;
            ST_HEAD0:            nxt = b ? ST_PAR_OD : ST_PAR_EV;
            ST_HEAD1:            nxt = b ? ST_PAR_EV : ST_PAR_OD;
            ST_PAR_EV, ST_PAR_OD: nxt = ST_IDLE;
            default:             nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // Third-bit decision: both prefix bits set, parity bit XOR incoming bit.
    function automatic logic tpd_frame_hit(input tpd_state_e cur, input logic b);
        return cur[2] & cur[1] & (cur[0] ^ b);
    endfunction

endpackage

// File: rtl/tpd_next_state.sv
module tpd_next_state
    import tpd_pkg::*;
(
    input  tpd_state_e cur_state,
    input  logic       bit_vld,
    input  logic       bit_in,
    output tpd_state_e nxt_state
);
    always_comb begin
        if (bit_vld) nxt_state = tpd_advance(cur_state, bit_in);
        else         nxt_state = cur_state;
    end
endmodule

// File: rtl/tpd_state_reg.sv
module tpd_state_reg
    import tpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tpd_state_e nxt_state,
    output tpd_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_IDLE;
        else     cur_state <= nxt_state;
    end
endmodule

// File: rtl/tpd_hit_logic.sv
module tpd_hit_logic
    import tpd_pkg::*;
(
    input  tpd_state_e cur_state,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic       hit
);
    always_comb hit = bit_vld & tpd_frame_hit(cur_state, bit_in);
endmodule

// File: rtl/triad_parity_detector.sv
module triad_parity_detector
    import tpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic z_out
);
    tpd_state_e state_q;
    tpd_state_e state_d;

    tpd_next_state i_next (
        .cur_state (state_q),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .nxt_state (state_d)
    );

    tpd_state_reg i_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    tpd_hit_logic i_hit (
        .cur_state (state_q),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .hit       (z_out)
    );

    // R1 / R6: reset always lands in idle
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);

    // R5: unqualified cycles keep the frame position
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(state_q));

    // R5: no detect without a qualified bit
    p_z_needs_vld_r5: assert property (@(posedge clk) disable iff (rst)
        z_out |-> bit_vld);

    // R3: detect only once two prefix bits are held
    p_no_early_z_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_HEAD0 || state_q == ST_HEAD1) |-> !z_out);

    // R4: a detect closes the frame
    p_frame_close_r4: assert property (@(posedge clk) disable iff (rst)
        z_out |=> state_q == ST_IDLE);

    // R2: third bit of a frame always returns to idle
    p_third_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && state_q[2] && state_q[1]) |=> state_q == ST_IDLE);

endmodule

// File: tb/test_triad_parity_detector.sv
module test_triad_parity_detector;
    logic clk = 1'b0;
    logic rst;
    logic bit_vld;
    logic bit_in;
    logic z_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model: accepted-bit count and ones count of the current frame
    int m_cnt  = 0;
    int m_ones = 0;

    always #5 clk = ~clk;

    triad_parity_detector i_triad_parity_detector (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .z_out   (z_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one clock: drive after falling edge, check output, update model at rising edge
    task automatic step(input logic r, input logic v, input logic b, input string tag);
        logic exp;
        @(negedge clk);
        rst = r; bit_vld = v; bit_in = b;
        #2;
        exp = (v && m_cnt == 2 && (((m_ones + int'(b)) % 2) == 1)) ? 1'b1 : 1'b0;
        checks++;
        if (z_out !== exp) begin
            failures++;
            $display("FAIL %s: z_out=%b expected=%b (cnt=%0d ones=%0d vld=%b bit=%b)",
                     tag, z_out, exp, m_cnt, m_ones, v, b);
        end
        @(posedge clk);
        if (r) begin
            m_cnt = 0; m_ones = 0;
        end else if (v) begin
            if (m_cnt == 2) begin
                m_cnt = 0; m_ones = 0;
            end else begin
                m_cnt++; m_ones += int'(b);
            end
        end
    endtask

    task automatic frame(input logic [2:0] f, input string tag);
        for (int i = 2; i >= 0; i--) step(1'b0, 1'b1, f[i], tag);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
        step(1'b1, 1'b0, 1'b0, "R1 reset");
        step(1'b1, 1'b1, 1'b1, "R1 reset");
        // R1: first frame after reset
        frame(3'b001, "R1 first frame");
        // R2: all eight frame values, back to back (R4 no overlap)
        for (int f = 0; f < 8; f++) frame(f[2:0], "R2 pattern");
        // R4: stream where sliding windows would hit across frames
        frame(3'b110, "R4 stream");
        frame(3'b000, "R4 stream");
        frame(3'b110, "R4 stream");
        frame(3'b011, "R4 stream");
        // R5: idle cycles inside frames with toggling data
        step(1'b0, 1'b1, 1'b1, "R5 gap");
        step(1'b0, 1'b0, 1'b1, "R5 gap");
        step(1'b0, 1'b0, 1'b0, "R5 gap");
        step(1'b0, 1'b1, 1'b1, "R5 gap");
        step(1'b0, 1'b0, 1'b0, "R5 gap");
        step(1'b0, 1'b1, 1'b1, "R5 gap");
        step(1'b0, 1'b0, 1'b1, "R5 gap");
        step(1'b0, 1'b1, 1'b0, "R5 gap");
        step(1'b0, 1'b1, 1'b0, "R5 gap");
        step(1'b0, 1'b0, 1'b1, "R5 gap");
        step(1'b0, 1'b1, 1'b0, "R5 gap");
        // R6: reset after two bits, then a fresh frame
        step(1'b0, 1'b1, 1'b0, "R6 midframe");
        step(1'b0, 1'b1, 1'b1, "R6 midframe");
        step(1'b1, 1'b0, 1'b0, "R6 midframe");
        frame(3'b100, "R6 after reset");
        step(1'b0, 1'b1, 1'b1, "R6 midframe");
        step(1'b1, 1'b1, 1'b0, "R6 midframe");
        frame(3'b111, "R6 after reset");
        // R3: mixed long run
        for (int k = 0; k < 60; k++)
            step(1'b0, (k % 5) != 3, ((k * 7) % 3) == 1, "R3 mixed");
        finish_run();
    end
endmodule